// File: doc/BRIEF.md
# Fixed-Point Low-Pass FIR with Power-of-Two Gain Normalisation

This block is a streaming finite-impulse-response low-pass filter for signed converter samples. Every accepted sample enters a tap delay line. Each tap is multiplied by a signed integer coefficient sized for an 18x18 hardware multiplier. The products are rounded to a narrower word and summed in an accumulator that carries enough guard bits for the tap count. The sum is then shifted right with rounding and clamped to the output width.

The coefficient set is meant to sum to exactly 2^SHIFT_N. With such a set, the total right shift of SHIFT_N bits restores unity gain at DC without a divider. That shift is split between the product stage and the final stage. A constant input therefore comes back as the same constant once the delay line is full.

Coefficients are written one at a time through an index, data and write-enable port while no sample is in flight. Samples stream in with a valid strobe. Results leave with their own valid strobe after a fixed pipeline delay.

Top module: `fir_pow2_lowpass`

## Requirements
- R1: After reset, `out_valid` is low, `out_data` is zero and every tap holds zero. The first N_TAPS-1 results after reset therefore use a zero-padded history.
- R2: A pulse on `coef_we` stores `coef_data` as coefficient number `coef_idx`. Index 0 multiplies the newest sample and index N_TAPS-1 multiplies the oldest. The new value applies to every later sample. Writes are issued only while no sample is in the pipeline.
- R3: A sample is accepted on every cycle that `in_valid` is high, and gap cycles between samples are allowed. Its result appears with `out_valid` high exactly 3 clock edges after the accepting edge. Each accepted sample produces exactly one result.
- R4: The accumulator is (IN_W+COEF_W-PROD_DROP)+ceil(log2(N_TAPS)) bits wide. No combination of full-scale samples and coefficients overflows it.
- R5: Each full product loses its PROD_DROP low bits through round-half-up: add 2^(PROD_DROP-1), then shift arithmetically.
- R6: The sum loses SHIFT_N-PROD_DROP further low bits through round-half-up. Ties are therefore rounded toward plus infinity, and a result of -0.5 output LSB becomes 0.
- R7: With coefficients summing to 2^SHIFT_N and a constant input x held for N_TAPS or more samples, the output equals x.
- R8: A normalised result above the OUT_W signed range gives the most positive code. A result below that range gives the most negative code. The output never wraps.
- R9: A single non-zero sample followed by zeros yields, in order, the rounded product of that sample with coefficient 0, then 1, up to N_TAPS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | IN_W | Signed input sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_idx | input | IDX_W | Coefficient index (0 = newest tap) |
| coef_data | input | COEF_W | Signed coefficient value |
| out_valid | output | 1 | Result strobe |
| out_data | output | OUT_W | Signed, rounded and clamped result |

## Verification
Each sample accepted at a rising edge has its result due after the third following edge: one edge for the taps, one for the products and one each for the sum and the output stage. The bench tags every accepted sample with the cycle count at its acceptance and queues the arithmetically computed result. It samples the outputs at the falling edge and requires each result to arrive in exactly the cycle its tag predicts. A result that arrives early, late or without a matching sample counts as a failure. Directed checks on single results wait until the pipeline has fully drained before they read the last output.

// File: rtl/fir_pkg.sv
package fir_pkg;

  typedef logic signed [63:0] wide_t;

  // Round-half-up right shift: add half of the dropped weight, then shift.
  function automatic wide_t rnd_shr(input wide_t v, input int unsigned sh);
    wide_t half;
    if (sh == 0) return v;
    half = wide_t'(1) <<< (sh - 1);
    return (v + half) >>> sh;
  endfunction

  // Clamp to a signed range of w bits.
  function automatic wide_t clamp(input wide_t v, input int unsigned w);
    wide_t hi;
    wide_t lo;
    hi = (wide_t'(1) <<< (w - 1)) - 1;
    lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/fir_tapline.sv
module fir_tapline #(
  parameter int N_TAPS = 8,
  parameter int IN_W   = 16,
  parameter int COEF_W = 18,
  parameter int IDX_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [IN_W-1:0]   in_data,
  input  logic                     coef_we,
  input  logic [IDX_W-1:0]         coef_idx,
  input  logic signed [COEF_W-1:0] coef_data,
  output logic                     tap_valid,
  output logic signed [IN_W-1:0]   smp_q [N_TAPS],
  output logic signed [COEF_W-1:0] coef_q [N_TAPS]
);

  logic idx_ok;
  assign idx_ok = int'(coef_idx) < N_TAPS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tap_valid <= 1'b0;
      for (int i = 0; i < N_TAPS; i++) smp_q[i] <= '0;
    end else begin
      tap_valid <= in_valid;
      if (in_valid) begin
        smp_q[0] <= in_data;
        for (int i = 1; i < N_TAPS; i++) smp_q[i] <= smp_q[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_TAPS; i++) coef_q[i] <= '0;
    end else if (coef_we && idx_ok) begin
      coef_q[coef_idx] <= coef_data;
    end
  end

  // R3: the line advances by one place per accepted sample
  a_r3_line_shift: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (smp_q[1] == $past(smp_q[0])));
  // R3: a gap cycle leaves the newest tap untouched
  a_r3_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(smp_q[0]));
  // R2: a write lands in the addressed coefficient
  a_r2_coef_store: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_we && idx_ok) |=> (coef_q[$past(coef_idx)] == $past(coef_data)));

endmodule

// File: rtl/fir_product.sv
module fir_product #(
  parameter int N_TAPS    = 8,
  parameter int IN_W      = 16,
  parameter int COEF_W    = 18,
  parameter int PROD_DROP = 2,
  localparam int FULL_W   = IN_W + COEF_W,
  localparam int PW       = FULL_W - PROD_DROP
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tap_valid,
  input  logic signed [IN_W-1:0]   smp_q [N_TAPS],
  input  logic signed [COEF_W-1:0] coef_q [N_TAPS],
  output logic                     prod_valid,
  output logic signed [PW-1:0]     prod_q [N_TAPS]
);
  import fir_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) prod_valid <= 1'b0;
    else        prod_valid <= tap_valid;
  end

  for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
    logic signed [FULL_W-1:0] full;
    logic signed [PW-1:0]     rounded;
    assign full    = smp_q[t] * coef_q[t];
    assign rounded = PW'(rnd_shr(wide_t'(full), PROD_DROP));
    always_ff @(posedge clk) begin
      if (!rst_n)         prod_q[t] <= '0;
      else if (tap_valid) prod_q[t] <= rounded;
    end
  end

  // R3: product stage follows the tap stage by one edge
  a_r3_prod_follow: assert property (@(posedge clk) disable iff (!rst_n)
    prod_valid |-> $past(tap_valid));

endmodule

// File: rtl/fir_sum_norm.sv
module fir_sum_norm #(
  parameter int N_TAPS  = 8,
  parameter int PW      = 32,
  parameter int FINAL_SH = 8,
  parameter int OUT_W   = 16,
  localparam int GUARD  = (N_TAPS > 1) ? $clog2(N_TAPS) : 1,
  localparam int ACC_W  = PW + GUARD
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    prod_valid,
  input  logic signed [PW-1:0]    prod_q [N_TAPS],
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  import fir_pkg::*;

  localparam logic signed [OUT_W-1:0] MAXV = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};

  wide_t                   sum_w;
  logic signed [ACC_W-1:0] acc_d;
  logic signed [ACC_W-1:0] acc_q;
  logic                    acc_valid;
  wide_t                   norm_w;
  wide_t                   clamp_w;
  logic                    sat_hit;

  always_comb begin
    sum_w = '0;
    for (int i = 0; i < N_TAPS; i++) sum_w = sum_w + wide_t'(prod_q[i]);
  end
  assign acc_d = ACC_W'(sum_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_q     <= '0;
    end else begin
      acc_valid <= prod_valid;
      if (prod_valid) acc_q <= acc_d;
    end
  end

  assign norm_w  = rnd_shr(wide_t'(acc_q), FINAL_SH);
  assign clamp_w = clamp(norm_w, OUT_W);
  assign sat_hit = (norm_w != clamp_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= acc_valid;
      if (acc_valid) out_data <= OUT_W'(clamp_w);
    end
  end

  // R4: the guard-extended accumulator holds the exact sum
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    prod_valid |-> (sum_w == wide_t'(acc_d)));
  // R8: an out-of-range result lands on a rail
  a_r8_sat_rail: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && sat_hit) |=> (out_data == MAXV || out_data == MINV));
  // R3: the output strobe follows the accumulator by one edge
  a_r3_out_follow: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(acc_valid));

endmodule

// File: rtl/fir_pow2_lowpass.sv
module fir_pow2_lowpass #(
  parameter int N_TAPS    = 8,
  parameter int IN_W      = 16,
  parameter int COEF_W    = 18,
  parameter int SHIFT_N   = 10,
  parameter int PROD_DROP = 2,
  parameter int OUT_W     = 16,
  localparam int IDX_W    = (N_TAPS > 1) ? $clog2(N_TAPS) : 1,
  localparam int PW       = IN_W + COEF_W - PROD_DROP,
  localparam int FINAL_SH = SHIFT_N - PROD_DROP
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [IN_W-1:0]   in_data,
  input  logic                     coef_we,
  input  logic [IDX_W-1:0]         coef_idx,
  input  logic signed [COEF_W-1:0] coef_data,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_data
);

  logic                     tap_valid;
  logic signed [IN_W-1:0]   smp_q  [N_TAPS];
  logic signed [COEF_W-1:0] coef_q [N_TAPS];
  logic                     prod_valid;
  logic signed [PW-1:0]     prod_q [N_TAPS];
  logic                     pipe_busy;

  fir_tapline #(.N_TAPS(N_TAPS), .IN_W(IN_W), .COEF_W(COEF_W), .IDX_W(IDX_W)) u_taps (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .coef_we(coef_we), .coef_idx(coef_idx), .coef_data(coef_data),
    .tap_valid(tap_valid), .smp_q(smp_q), .coef_q(coef_q));

  fir_product #(.N_TAPS(N_TAPS), .IN_W(IN_W), .COEF_W(COEF_W), .PROD_DROP(PROD_DROP)) u_prod (
    .clk(clk), .rst_n(rst_n), .tap_valid(tap_valid), .smp_q(smp_q), .coef_q(coef_q),
    .prod_valid(prod_valid), .prod_q(prod_q));

  fir_sum_norm #(.N_TAPS(N_TAPS), .PW(PW), .FINAL_SH(FINAL_SH), .OUT_W(OUT_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .prod_valid(prod_valid), .prod_q(prod_q),
    .out_valid(out_valid), .out_data(out_data));

  assign pipe_busy = in_valid | tap_valid | prod_valid;

  // R2: coefficient writes only while the pipeline is empty
  a_r2_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we |-> !pipe_busy);
  // R1: nothing leaves the block in the cycle right after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

// File: tb/test_fir_pow2_lowpass.sv
module test_fir_pow2_lowpass;

  localparam int NT = 8;
  localparam longint OMAX = 32767;
  localparam longint OMIN = -32768;

  logic               clk;
  logic               rst_n;
  logic               in_valid;
  logic signed [15:0] in_data;
  logic               coef_we;
  logic [2:0]         coef_idx;
  logic signed [17:0] coef_data;
  logic               out_valid;
  logic signed [15:0] out_data;

  fir_pow2_lowpass i_fir_pow2_lowpass (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .coef_we(coef_we), .coef_idx(coef_idx), .coef_data(coef_data),
    .out_valid(out_valid), .out_data(out_data));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int     tests = 0;
  int     fails = 0;
  int     cyc = 0;
  int     n_in = 0;
  int     n_out = 0;
  longint last_out = 0;
  string  cur_tag = "R1";
  longint mh [NT];
  longint mc [NT];
  longint exp_q [$];
  int     due_q [$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint fdiv(input longint a, input longint b);
    longint q;
    q = a / b;
    if ((a % b) != 0 && a < 0) q = q - 1;
    return q;
  endfunction

  function automatic longint model_out();
    longint s;
    longint r;
    s = 0;
    for (int i = 0; i < NT; i++) s += fdiv(mh[i] * mc[i] + 2, 4);   // R5
    r = fdiv(s + 128, 256);                                          // R6
    if (r > OMAX) r = OMAX;                                          // R8
    if (r < OMIN) r = OMIN;
    return r;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) begin mh[i] = 0; mc[i] = 0; end
    end else begin
      if (coef_we) mc[coef_idx] = longint'(coef_data);
      if (in_valid) begin
        for (int i = NT - 1; i > 0; i--) mh[i] = mh[i-1];
        mh[0] = longint'(in_data);
        exp_q.push_back(model_out());
        due_q.push_back(cyc + 4);
        n_in++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        n_out++;
        last_out = longint'(out_data);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected result", longint'(out_data), 0);
        end else begin
          longint e;
          int d;
          e = exp_q.pop_front();
          d = due_q.pop_front();
          chk(d == cyc, "R3 latency", cyc, d);
          chk(longint'(out_data) == e, cur_tag, longint'(out_data), e);
        end
      end else if (due_q.size() != 0 && due_q[0] <= cyc) begin
        chk(1'b0, "R3 missing result", cyc, due_q[0]);
        void'(exp_q.pop_front());
        void'(due_q.pop_front());
      end
    end
  end

  task automatic send(input longint x, input int gap);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'(x);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic load(input int c [NT]);
    for (int i = 0; i < NT; i++) begin
      @(negedge clk);
      coef_we   = 1'b1;
      coef_idx  = 3'(i);
      coef_data = 18'(c[i]);
    end
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lcg;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    coef_we = 1'b0; coef_idx = '0; coef_data = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
    chk(out_data == 16'sd0, "R1 out_data in reset", longint'(out_data), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);

    // R2 R9 with R1 zero history: impulse response
    load('{64, 128, 192, 128, 256, 128, 64, 64});
    cur_tag = "R1 R2 R9 impulse";
    send(1024, 1);
    for (int k = 0; k < 9; k++) send(0, 1);
    drain();

    // R7 DC unity gain, gaps between samples
    cur_tag = "R7 dc";
    for (int k = 0; k < 12; k++) send(12345, k % 3);
    drain();
    chk(last_out == 12345, "R7 dc positive", last_out, 12345);
    for (int k = 0; k < 10; k++) send(-20000, 1);
    drain();
    chk(last_out == -20000, "R7 dc negative", last_out, -20000);
    for (int k = 0; k < 10; k++) send(-32768, 1);
    drain();
    chk(last_out == -32768, "R7 dc full scale", last_out, -32768);

    // R5 product rounding: 2*255=510 -> 128 (half up) -> final 1
    load('{2, 0, 0, 0, 0, 0, 0, 0});
    cur_tag = "R5 rounding";
    send(255, 1);
    drain();
    chk(last_out == 1, "R5 product half up", last_out, 1);

    // R6 final rounding: 512 -> 0.5 LSB -> 1, -512 -> -0.5 LSB -> 0
    load('{1, 0, 0, 0, 0, 0, 0, 0});
    cur_tag = "R6 rounding";
    send(512, 1);
    drain();
    chk(last_out == 1, "R6 final +half", last_out, 1);
    send(-512, 1);
    drain();
    chk(last_out == 0, "R6 final -half", last_out, 0);

    // R8 saturation with alternating input
    load('{4096, -4096, 0, 0, 0, 0, 0, 0});
    cur_tag = "R8 saturation";
    send(32767, 1);
    send(-32768, 1);
    drain();
    chk(last_out == OMIN, "R8 negative rail", last_out, OMIN);
    send(32767, 1);
    drain();
    chk(last_out == OMAX, "R8 positive rail", last_out, OMAX);

    // R4 full-scale guard bits: result sign must survive
    load('{-131072, -131072, -131072, -131072, -131072, -131072, -131072, -131072});
    cur_tag = "R4 full scale";
    for (int k = 0; k < 8; k++) send(-32768, 0);
    drain();
    chk(last_out == OMAX, "R4 max positive sum", last_out, OMAX);
    load('{131071, 131071, 131071, 131071, 131071, 131071, 131071, 131071});
    for (int k = 0; k < 8; k++) send(-32768, 0);
    drain();
    chk(last_out == OMIN, "R4 max negative sum", last_out, OMIN);

    // R5 R6 sweep with a mixed-sign set summing to 1024
    load('{-40, 100, 300, 152, 300, 250, 0, -38});
    cur_tag = "R5 R6 R3 sweep";
    lcg = 32'h1234_5678;
    for (int k = 0; k < 3000; k++) begin
      lcg = lcg * 1103515245 + 12345;
      send(longint'($signed(lcg[30:15])), (lcg[3:2] == 2'b00) ? 2 : 1);
    end
    drain();

    chk(n_out == n_in, "R3 result count", n_out, n_in);
    chk(exp_q.size() == 0, "R3 queue drained", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule